// File: doc/BRIEF.md
# Photon Window Delay Calibration Controller

This controller lines up a single-photon detector gate with photon arrivals. It steps programmable delay lines and watches photon-hit feedback while it does so. A one-cycle pulse on either of two start pins begins a run. The host pin and the local switch pin have the same effect. The controller then works through three stages.

The first stage is a fixed load of start-up delay words. The second is a coarse search on the long delay. It ends only when a run of consecutive in-window trials is seen at one setting. The third stage is two fine searches, one for each channel, run one after the other. A fine search ends when the hit total it has collected over a setting equals the wanted total of zero. At that point the photon has just left the start of the window.

Every delay word goes out on one shared bus, and each delay device has its own latch strobe. While calibration runs, a mixer-enable output stays high. The run ends either with a held completion flag or with a held error that also lights every error LED. Control and status pins are plain levels or pulses. The block has no streamed data path, so there is no valid/ready handshake.

Top module: `photon_cal_ctrl`

## Requirements
- R1: After reset, `mix_en`, `sync_done`, `cal_err`, every bit of `dly_le` and every bit of `err_led` are low.
- R2: A high level on `host_start` or on `sw_start` during one clock starts a run from idle, from done or from error. Either pin has the same effect. A start that arrives while a run is in progress has no effect: it causes no extra bus write, and the results do not change.
- R3: A run starts with seven writes in this order: word 0 to device 0, 1, 2, 3 and 4 in turn, then `STRETCH_WORD` (default 70) to device 3, then `MONO_WORD` (default 6) to device 4. Device 0 is the coarse delay, 1 is fine channel 1, 2 is fine channel 2, 3 is the pulse stretcher and 4 is the one-shot width.
- R4: Each write puts the word on `dly_word` one cycle before a single-cycle strobe on exactly one `dly_le` bit, where bit k strobes device k. The word holds during the strobe, and at least one cycle with no strobe follows every strobe.
- R5: The coarse stage runs trials of `TRIAL_CYC` cycles. A trial counts as a hit if the channel-1 hit is high in any cycle of it. The stage ends on the first setting that gives `HITS_NEEDED` (default 5) hits in a row among `TRIALS` (default 6) trials. Each setting that fails adds one to the coarse word and writes it.
- R6: Fine channel 1 starts only after the coarse stage ends, and fine channel 2 only after channel 1 ends. Each checks its own hit input. Each steps its own word up from 0 by one until a setting gives zero hits over all `TRIALS` trials. The two channels may settle at different words.
- R7: `mix_en` is high from the cycle after a start is accepted until the run completes or fails, and it is low at all other times.
- R8: On completion `sync_done` goes high and stays high until the next start. At that point the three tuned words are the last ones latched into devices 0, 1 and 2.
- R9: If a search fails at the all-ones word, the run stops. `cal_err` and every `err_led` bit go high, `mix_en` goes low, and no further strobes are issued until the next start.
- R10: When `use_sim` is 1, hits come from `sim_hit1`/`sim_hit2` and the receiver strobes are ignored. When it is 0, hits come from `rx_hit1`/`rx_hit2` and the simulated inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_start | input | 1 | Start request from the host |
| sw_start | input | 1 | Start request from the board switch |
| use_sim | input | 1 | 1 selects simulated photon inputs |
| rx_hit1 | input | 1 | Receiver photon strobe, channel 1 |
| rx_hit2 | input | 1 | Receiver photon strobe, channel 2 |
| sim_hit1 | input | 1 | Simulated valid photon, channel 1 |
| sim_hit2 | input | 1 | Simulated valid photon, channel 2 |
| dly_word | output | DW | Shared delay-word bus |
| dly_le | output | 5 | Per-device latch strobes |
| mix_en | output | 1 | Mixer enable, high while calibrating |
| sync_done | output | 1 | Calibration complete |
| cal_err | output | 1 | Calibration failed |
| err_led | output | LED_N | Error LEDs, all lit on failure |

## Verification
`mix_en` is due one cycle after the clock edge that samples a start pulse. The bench reads it at the falling edge right after the start cycle. A strobe follows its bus word by exactly one cycle. A bench monitor compares bus and strobes at every falling edge, so it checks the word-before-strobe rule, single-bit strobes and the idle gap on every write, with no timing guesswork. Tuned words, strobe counts and the final flags are checked once `sync_done` or `cal_err` rises, and again 20 cycles later to show that they hold. The photon model uses only the words latched on the bus, so the expected result is known before the run starts.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_DEV     = 5;
  localparam int DEVW        = $clog2(NUM_DEV);
  localparam int DEV_COARSE  = 0;
  localparam int DEV_FINE1   = 1;
  localparam int DEV_FINE2   = 2;
  localparam int DEV_STRETCH = 3;
  localparam int DEV_MONO    = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_CTR, S_CWR, S_F1TR, S_F1WR, S_F2TR, S_F2WR, S_DONE, S_ERR
  } cal_state_t;

  typedef enum logic [1:0] {W_IDLE, W_PUT, W_STB, W_GAP} wr_state_t;
endpackage

// File: rtl/cal_bus_writer.sv
module cal_bus_writer
  import cal_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [DEVW-1:0]    dev,
  input  logic [DW-1:0]      word,
  output logic [DW-1:0]      bus_word,
  output logic [NUM_DEV-1:0] bus_le,
  output logic               idle,
  output logic               done
);
  wr_state_t       st;
  logic [DEVW-1:0] dev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      dev_q    <= '0;
      bus_word <= '0;
    end else begin
      case (st)
        W_IDLE: if (go) begin
          bus_word <= word;
          dev_q    <= dev;
          st       <= W_PUT;
        end
        W_PUT:   st <= W_STB;
        W_STB:   st <= W_GAP;
        default: st <= W_IDLE;
      endcase
    end
  end

  // one strobe register per device, set for the single cycle after PUT
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_le
    always_ff @(posedge clk) begin
      if (!rst_n) bus_le[g] <= 1'b0;
      else        bus_le[g] <= (st == W_PUT) && (dev_q == DEVW'(g));
    end
  end

  assign idle = (st == W_IDLE);
  assign done = (st == W_GAP);

  AST_LE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_le)); // R4
  AST_LE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_le) |=> !(|bus_le)); // R4
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_le) |-> $stable(bus_word)); // R4
endmodule

// File: rtl/cal_trial_window.sv
module cal_trial_window #(
  parameter int TRIAL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hit,
  output logic idle,
  output logic done,
  output logic hit_seen
);
  localparam int CW = $clog2(TRIAL_CYC + 1);

  logic          active;
  logic          seen;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      seen     <= 1'b0;
      cnt      <= '0;
      done     <= 1'b0;
      hit_seen <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          seen   <= 1'b0;
          cnt    <= CW'(TRIAL_CYC - 1);
        end
      end else begin
        seen <= seen | hit;
        if (cnt == '0) begin
          active   <= 1'b0;
          done     <= 1'b1;
          hit_seen <= seen | hit;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign idle = !active;

  AST_DONE_ENDS_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(active)); // R5
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_pkg::*;
#(
  parameter int DW           = 10,
  parameter int TRIALS       = 6,
  parameter int HITS_NEEDED  = 5,
  parameter int STRETCH_WORD = 70,
  parameter int MONO_WORD    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wr_idle,
  input  logic            wr_done,
  input  logic            tr_idle,
  input  logic            tr_done,
  input  logic            tr_hit,
  output logic            wr_go,
  output logic [DEVW-1:0] wr_dev,
  output logic [DW-1:0]   wr_word,
  output logic            tr_start,
  output logic            use_ch2,
  output logic            mix_en,
  output logic            sync_done,
  output logic            cal_err
);
  localparam int TW = $clog2(TRIALS + 1);
  localparam int HW = $clog2(HITS_NEEDED + 1);
  localparam logic [DW-1:0] MAXW = {DW{1'b1}};
  localparam logic [2:0] IDX_LAST = 3'(NUM_DEV + 1);

  cal_state_t    st;
  logic [2:0]    init_idx;
  logic [DW-1:0] coarse_w, fine1_w, fine2_w, cur_fine;
  logic [HW-1:0] streak;
  logic [TW-1:0] trials, hits;
  logic          in_trial, last_trial;

  assign in_trial   = (st == S_CTR) || (st == S_F1TR) || (st == S_F2TR);
  assign last_trial = (trials == TW'(TRIALS - 1));
  assign use_ch2    = (st == S_F2TR);
  assign cur_fine   = use_ch2 ? fine2_w : fine1_w;
  assign wr_go      = wr_idle && ((st == S_INIT) || (st == S_CWR) ||
                                  (st == S_F1WR) || (st == S_F2WR));
  assign tr_start   = in_trial && tr_idle && !tr_done;
  assign mix_en     = !((st == S_IDLE) || (st == S_DONE) || (st == S_ERR));
  assign sync_done  = (st == S_DONE);
  assign cal_err    = (st == S_ERR);

  always_comb begin
    wr_dev  = DEVW'(DEV_COARSE);
    wr_word = coarse_w;
    case (st)
      S_INIT: begin
        if (init_idx < 3'(NUM_DEV)) begin
          wr_dev  = DEVW'(init_idx);
          wr_word = '0;
        end else if (init_idx == 3'(NUM_DEV)) begin
          wr_dev  = DEVW'(DEV_STRETCH);
          wr_word = DW'(STRETCH_WORD);
        end else begin
          wr_dev  = DEVW'(DEV_MONO);
          wr_word = DW'(MONO_WORD);
        end
      end
      S_F1WR: begin wr_dev = DEVW'(DEV_FINE1); wr_word = fine1_w; end
      S_F2WR: begin wr_dev = DEVW'(DEV_FINE2); wr_word = fine2_w; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      init_idx <= '0;
      coarse_w <= '0;
      fine1_w  <= '0;
      fine2_w  <= '0;
      streak   <= '0;
      trials   <= '0;
      hits     <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_ERR: if (start) begin
          st       <= S_INIT;
          init_idx <= '0;
          coarse_w <= '0;
          fine1_w  <= '0;
          fine2_w  <= '0;
          streak   <= '0;
          trials   <= '0;
          hits     <= '0;
        end
        S_INIT: if (wr_done) begin
          if (init_idx == IDX_LAST) st <= S_CTR;
          else                      init_idx <= init_idx + 1'b1;
        end
        S_CWR:  if (wr_done) st <= S_CTR;
        S_F1WR: if (wr_done) st <= S_F1TR;
        S_F2WR: if (wr_done) st <= S_F2TR;
        S_CTR: if (tr_done) begin
          if (tr_hit && streak == HW'(HITS_NEEDED - 1)) begin
            st     <= S_F1TR;
            streak <= '0;
            trials <= '0;
          end else if (last_trial) begin
            streak <= '0;
            trials <= '0;
            if (coarse_w == MAXW) st <= S_ERR;
            else begin
              coarse_w <= coarse_w + 1'b1;
              st       <= S_CWR;
            end
          end else begin
            streak <= tr_hit ? streak + 1'b1 : '0;
            trials <= trials + 1'b1;
          end
        end
        S_F1TR, S_F2TR: if (tr_done) begin
          if (last_trial) begin
            trials <= '0;
            hits   <= '0;
            if ((hits + TW'(tr_hit)) == '0) begin
              st <= use_ch2 ? S_DONE : S_F2TR;
            end else if (cur_fine == MAXW) begin
              st <= S_ERR;
            end else if (use_ch2) begin
              fine2_w <= fine2_w + 1'b1;
              st      <= S_F2WR;
            end else begin
              fine1_w <= fine1_w + 1'b1;
              st      <= S_F1WR;
            end
          end else begin
            trials <= trials + 1'b1;
            hits   <= hits + TW'(tr_hit);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ERR_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERR && $past(st) != S_ERR) |->
      (coarse_w == MAXW || fine1_w == MAXW || fine2_w == MAXW)); // R9
  AST_FINE2_AFTER_FINE1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F2TR && $past(st) != S_F2TR) |->
      ($past(st) == S_F1TR || $past(st) == S_F2WR)); // R6
  AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_en && st != S_INIT) |=> (st != S_INIT)); // R2
endmodule

// File: rtl/photon_cal_ctrl.sv
module photon_cal_ctrl
  import cal_pkg::*;
#(
  parameter int DW           = 10,
  parameter int TRIALS       = 6,
  parameter int HITS_NEEDED  = 5,
  parameter int TRIAL_CYC    = 4,
  parameter int STRETCH_WORD = 70,
  parameter int MONO_WORD    = 6,
  parameter int LED_N        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_start,
  input  logic               sw_start,
  input  logic               use_sim,
  input  logic               rx_hit1,
  input  logic               rx_hit2,
  input  logic               sim_hit1,
  input  logic               sim_hit2,
  output logic [DW-1:0]      dly_word,
  output logic [NUM_DEV-1:0] dly_le,
  output logic               mix_en,
  output logic               sync_done,
  output logic               cal_err,
  output logic [LED_N-1:0]   err_led
);
  logic [1:0]      rx_v, sim_v, ch_hit;
  logic            wr_go, wr_idle, wr_done;
  logic [DEVW-1:0] wr_dev;
  logic [DW-1:0]   wr_word;
  logic            tr_start, tr_idle, tr_done, tr_hit_seen, use_ch2;

  assign rx_v  = {rx_hit2, rx_hit1};
  assign sim_v = {sim_hit2, sim_hit1};

  for (genvar c = 0; c < 2; c++) begin : g_src
    assign ch_hit[c] = use_sim ? sim_v[c] : rx_v[c];
  end

  cal_sequencer #(
    .DW(DW), .TRIALS(TRIALS), .HITS_NEEDED(HITS_NEEDED),
    .STRETCH_WORD(STRETCH_WORD), .MONO_WORD(MONO_WORD)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(host_start | sw_start),
    .wr_idle(wr_idle), .wr_done(wr_done),
    .tr_idle(tr_idle), .tr_done(tr_done), .tr_hit(tr_hit_seen),
    .wr_go(wr_go), .wr_dev(wr_dev), .wr_word(wr_word),
    .tr_start(tr_start), .use_ch2(use_ch2),
    .mix_en(mix_en), .sync_done(sync_done), .cal_err(cal_err)
  );

  cal_bus_writer #(.DW(DW)) wr_i (
    .clk(clk), .rst_n(rst_n), .go(wr_go), .dev(wr_dev), .word(wr_word),
    .bus_word(dly_word), .bus_le(dly_le), .idle(wr_idle), .done(wr_done)
  );

  cal_trial_window #(.TRIAL_CYC(TRIAL_CYC)) trial_i (
    .clk(clk), .rst_n(rst_n), .start(tr_start),
    .hit(use_ch2 ? ch_hit[1] : ch_hit[0]),
    .idle(tr_idle), .done(tr_done), .hit_seen(tr_hit_seen)
  );

  assign err_led = {LED_N{cal_err}};

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_done && !host_start && !sw_start) |=> sync_done); // R8
  AST_NO_WRITE_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |-> (dly_le == '0)); // R9
  AST_MIX_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_done || cal_err) |-> !mix_en); // R7
endmodule

// File: tb/photon_cal_ctrl_tb_top.sv
module photon_cal_ctrl_tb_top;
  localparam int DW = 10, ND = 5, TRIALS = 6, HN = 5, TC = 4, P = TC + 2;
  localparam int LED_N = 4, STRETCH = 70, MONO = 6, MAXW = (1 << DW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, host_start = 1'b0, sw_start = 1'b0, use_sim = 1'b0;
  logic rx_hit1 = 1'b0, rx_hit2 = 1'b0, sim_hit1 = 1'b0, sim_hit2 = 1'b0;
  logic [DW-1:0] dly_word;
  logic [ND-1:0] dly_le;
  logic mix_en, sync_done, cal_err;
  logic [LED_N-1:0] err_led;

  photon_cal_ctrl #(.DW(DW), .TRIALS(TRIALS), .HITS_NEEDED(HN), .TRIAL_CYC(TC),
    .STRETCH_WORD(STRETCH), .MONO_WORD(MONO), .LED_N(LED_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .sw_start(sw_start),
    .use_sim(use_sim), .rx_hit1(rx_hit1), .rx_hit2(rx_hit2),
    .sim_hit1(sim_hit1), .sim_hit2(sim_hit2), .dly_word(dly_word),
    .dly_le(dly_le), .mix_en(mix_en), .sync_done(sync_done),
    .cal_err(cal_err), .err_led(err_led));

  int n_chk = 0, n_bad = 0;
  int lat [ND];
  int strobes = 0, burst = 0, proto_bad = 0;
  int log_dev [8];
  int log_word [8];
  int ct = 0, f1t = 1, f2t = 1;
  int prev_word = 0;
  bit prev_le = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int init_dev(input int i);
    if (i < ND) return i;
    return (i == ND) ? 3 : 4;
  endfunction
  function automatic int init_word(input int i);
    if (i < ND) return 0;
    return (i == ND) ? STRETCH : MONO;
  endfunction
  function automatic int exp_strobes(input int c, input int a, input int b);
    return ND + 2 + c + a + b;
  endfunction

  // monitor of bus protocol plus photon model, away from the active edge
  always @(negedge clk) begin
    bit h1, h2;
    if (!rst_n) begin
      for (int d = 0; d < ND; d++) lat[d] = 0;
      burst = 0;
    end else if (|dly_le) begin
      if (!$onehot(dly_le) || int'(dly_word) != prev_word || prev_le) proto_bad++;
      for (int d = 0; d < ND; d++) if (dly_le[d]) lat[d] = int'(dly_word);
      if (strobes < 8) begin
        for (int d = 0; d < ND; d++) if (dly_le[d]) log_dev[strobes] = d;
        log_word[strobes] = int'(dly_word);
      end
      strobes++;
      burst = 2 * P;
    end else if (burst > 0) begin
      burst--;
    end
    prev_word = int'(dly_word);
    prev_le = |dly_le;
    h1 = (lat[0] >= ct) ? (lat[1] < f1t) : (burst > 0);
    h2 = (lat[0] >= ct) && (lat[2] < f2t);
    if (use_sim) begin
      sim_hit1 = h1; sim_hit2 = h2; rx_hit1 = ~h1; rx_hit2 = ~h2;
    end else begin
      rx_hit1 = h1; rx_hit2 = h2; sim_hit1 = ~h1; sim_hit2 = ~h2;
    end
  end

  task automatic run(input int c, input int a, input int b, input bit sim,
                     input bit sw, input bit mid, input bit exp_err);
    int cyc;
    int s_end;
    ct = c; f1t = a; f2t = b;
    use_sim = sim;
    strobes = 0;
    @(negedge clk);
    if (sw) sw_start = 1'b1; else host_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0; host_start = 1'b0;
    check("R7 mix_en high after start", int'(mix_en), 1);
    check("R2 done cleared by start", int'(sync_done), 0);
    if (mid) begin
      repeat (30) @(negedge clk);
      host_start = 1'b1;
      @(negedge clk);
      host_start = 1'b0;
    end
    cyc = 0;
    while (!(sync_done || cal_err) && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    check("watchdog run ended", int'(cyc < 60000), 1);
    for (int i = 0; i < ND + 2; i++) begin
      check("R3 init device order", log_dev[i], init_dev(i));
      check("R3 init word", log_word[i], init_word(i));
    end
    check("R4 bus protocol violations", proto_bad, 0);
    check("R7 mix_en low at end", int'(mix_en), 0);
    if (exp_err) begin
      check("R9 cal_err", int'(cal_err), 1);
      check("R9 err_led all lit", int'(err_led), (1 << LED_N) - 1);
      check("R9 coarse word at max", lat[0], MAXW);
      check("R9 strobe count", strobes, ND + 2 + MAXW);
    end else begin
      check("R8 sync_done", int'(sync_done), 1);
      check("R9 no error", int'(cal_err), 0);
      check("R5 coarse word", lat[0], c);
      check("R6 fine1 word", lat[1], a);
      check("R6 fine2 word", lat[2], b);
      check("R2 strobe count (mid start ignored)", strobes, exp_strobes(c, a, b));
      check("R10 source select run", int'(sim), int'(use_sim));
    end
    s_end = strobes;
    repeat (20) @(negedge clk);
    check("R8 R9 flags held", int'({sync_done, cal_err}), exp_err ? 1 : 2);
    check("R9 no writes after end", strobes, s_end);
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 190000) begin @(negedge clk); wd++; end
        check("watchdog", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R1 mix_en reset", int'(mix_en), 0);
    check("R1 flags reset", int'({sync_done, cal_err}), 0);
    check("R1 strobes reset", int'(dly_le), 0);
    check("R1 leds reset", int'(err_led), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle without start", int'(mix_en), 0);
    // directed: photon already in window, smallest fine targets
    run(0, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    // directed: switch start, different fine settle points, mid-run start
    run(3, 7, 2, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      run(int'($urandom_range(0, 12)), int'($urandom_range(1, 12)),
          int'($urandom_range(1, 12)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0);
    end
    // coarse search never reaches five in a row: error at all-ones word
    run(5000, 1, 1, 1'b1, 1'b0, 1'b0, 1'b1);
    // restart from error
    run(2, 4, 9, 1'b0, 1'b1, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule